// File: doc/BRIEF.md
# Fixed-Last-Bank PRG Bank Switcher

This block sits on the cartridge side of a 6502-style CPU bus and extends the program ROM beyond the 32 KiB that the CPU can reach directly. It keeps a small bank register and forms the upper ROM address lines from it. The cartridge's 32 KiB ROM space is split into two 16 KiB windows. Any 16 KiB bank of the ROM can appear in the lower window at $8000-$BFFF. The upper window at $C000-$FFFF always shows the highest bank, so reset vectors and fixed code stay reachable whatever bank is selected.

Software selects a bank by storing to any address in $C000-$FFFF. The block captures the low data bits on the falling edge of M2. The ROM chip enable is active only for CPU reads of cartridge space. This means the ROM never drives the data bus while the CPU is driving a bank number onto it, so the data value written is the value stored. The fixed upper bank can be built in either of two ways, chosen by a parameter. One ORs each bank bit with CPU A14. The other lets the register stop driving its lines when A14 is high and relies on pull-ups to force them high. Both give the same addresses.

The bus signals carry no data stream that can be stalled, so the block has no valid/ready handshake. Every port is a plain control or address signal, and the outputs follow the bus within the same bus cycle.

Top module: `prg_bank_mapper`

## Requirements
- R1: prg_addr[13:0] equals cpu_addr[13:0] at all times.
- R2: When cpu_addr[14] is 1, prg_addr[16:14] is 3'b111, the last bank, whatever the register holds.
- R3: When cpu_addr[14] is 0, prg_addr[16:14] equals the 3-bit bank register.
- R4: On a falling edge of m2, the register loads cpu_data[2:0] when rom_sel_n is 0, cpu_rw is 0 (write) and cpu_addr[14] is 1. These are CPU writes to $C000-$FFFF. cpu_data[7:3] is discarded.
- R5: A CPU write to $8000-$BFFF (rom_sel_n 0, cpu_addr[14] 0) leaves the register unchanged.
- R6: CPU reads, and CPU writes below $8000 (rom_sel_n 1), leave the register unchanged, even when cpu_addr[14] is 1.
- R7: rom_ce_n is 0 exactly when rom_sel_n is 0 and cpu_rw is 1. It is therefore 1 during every CPU write.
- R8: While rst_n is 0 the register is held at 0, asynchronously, so the lower window shows bank 0.
- R9: With FORM set to HI_PULLUP, where lines are released and pulled high, every output matches the default HI_OR_GATE build for the same bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the bank register |
| m2 | input | 1 | CPU phase-2 clock; the register captures on its falling edge |
| cpu_rw | input | 1 | CPU read/write strobe, 1 = read, 0 = write |
| rom_sel_n | input | 1 | Active-low select for CPU accesses to $8000-$FFFF during M2 high |
| cpu_addr | input | 15 | CPU address bits A14..A0 |
| cpu_data | input | 8 | CPU data bus as seen on a write |
| prg_addr | output | 17 | PRG ROM address: bank lines A16..A14 and A13..A0 passed through |
| rom_ce_n | output | 1 | Active-low PRG ROM chip enable, reads of cartridge space only |

## Verification
The bench loads every bank number, each time with non-zero upper data bits. It then reads addresses spread across both windows to confirm that the upper window stays on bank 7 and the lower window follows the register. A decoder that ignored A14 would bank-switch the fixed window. A register that kept more than three data bits, or that latched on the wrong M2 edge, would show the wrong bank in the lower window. Stores to $8000-$BFFF, stores below $8000 that have A14 set, and reads of $C000-$FFFF are each followed by a read of the lower window. These show up a register that loads outside its own window or on reads. The chip enable is compared on every cycle, so a ROM enabled during writes would be caught as a bus conflict. A reset applied partway through the run must return the lower window to bank 0. A second instance built in the pull-up form must match the OR form on every cycle.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  // How the fixed upper window forces the bank lines to all ones.
  typedef enum logic {
    HI_OR_GATE = 1'b0,  // bank bits ORed with CPU A14
    HI_PULLUP  = 1'b1   // register released on A14 high, lines pulled up
  } hi_form_e;

  localparam int unsigned DEF_BANK_W = 3;
  localparam int unsigned DEF_WIN_W  = 14;
  localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/prg_addr_decode.sv
module prg_addr_decode (
  input  logic cpu_rw,
  input  logic rom_sel_n,
  input  logic win_hi,
  output logic reg_wr_hit,
  output logic rom_ce_n
);

  logic cart_space;
  logic is_read;

  assign cart_space = ~rom_sel_n;
  assign is_read    = cpu_rw;

  // Register lives only in the upper window and only answers writes.
  assign reg_wr_hit = cart_space & ~is_read & win_hi;

  // ROM drives the bus only on reads, so no store can collide with it.
  assign rom_ce_n   = ~(cart_space & is_read);

endmodule

// File: rtl/prg_bank_reg.sv
module prg_bank_reg #(
  parameter int unsigned BANK_W = prg_map_pkg::DEF_BANK_W,
  parameter int unsigned DATA_W = prg_map_pkg::DEF_DATA_W
) (
  input  logic              m2,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] data_in,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_d;

  assign bank_d = data_in[BANK_W-1:0];

  always_ff @(negedge m2 or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_hit) begin
      bank_q <= bank_d;
    end
  end

  // R4: a qualifying store lands in the register at the M2 fall.
  p_load_r4: assert property (@(negedge m2) disable iff (!rst_n)
    wr_hit |=> (bank_q == $past(data_in[BANK_W-1:0])));

  // R5 / R6: anything else leaves the bank untouched.
  p_hold_r5: assert property (@(negedge m2) disable iff (!rst_n)
    !wr_hit |=> $stable(bank_q));

  // R8: reset holds bank 0.
  p_reset_r8: assert property (@(negedge m2)
    !rst_n |-> (bank_q == '0));

endmodule

// File: rtl/prg_hi_lines.sv
module prg_hi_lines #(
  parameter int unsigned          BANK_W = prg_map_pkg::DEF_BANK_W,
  parameter prg_map_pkg::hi_form_e FORM  = prg_map_pkg::HI_OR_GATE
) (
  input  logic [BANK_W-1:0] bank_q,
  input  logic              fix_last,
  output logic [BANK_W-1:0] hi_out
);

  generate
    if (FORM == prg_map_pkg::HI_OR_GATE) begin : g_or_form
      assign hi_out = bank_q | {BANK_W{fix_last}};
    end else begin : g_pullup_form
      logic drive_en;
      assign drive_en = ~fix_last;
      for (genvar i = 0; i < BANK_W; i++) begin : g_line
        // A released line is resolved by its pull-up to one.
        assign hi_out[i] = drive_en ? bank_q[i] : 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int unsigned           BANK_W = prg_map_pkg::DEF_BANK_W,
  parameter int unsigned           WIN_W  = prg_map_pkg::DEF_WIN_W,
  parameter int unsigned           DATA_W = prg_map_pkg::DEF_DATA_W,
  parameter prg_map_pkg::hi_form_e FORM   = prg_map_pkg::HI_OR_GATE
) (
  input  logic                    rst_n,
  input  logic                    m2,
  input  logic                    cpu_rw,
  input  logic                    rom_sel_n,
  input  logic [WIN_W:0]          cpu_addr,
  input  logic [DATA_W-1:0]       cpu_data,
  output logic [WIN_W+BANK_W-1:0] prg_addr,
  output logic                    rom_ce_n
);

  localparam int unsigned PRG_W = WIN_W + BANK_W;

  logic              win_hi;
  logic              reg_wr_hit;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] hi_lines;

  assign win_hi = cpu_addr[WIN_W];

  prg_addr_decode u_decode (
    .cpu_rw    (cpu_rw),
    .rom_sel_n (rom_sel_n),
    .win_hi    (win_hi),
    .reg_wr_hit(reg_wr_hit),
    .rom_ce_n  (rom_ce_n)
  );

  prg_bank_reg #(
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
  ) u_reg (
    .m2     (m2),
    .rst_n  (rst_n),
    .wr_hit (reg_wr_hit),
    .data_in(cpu_data),
    .bank_q (bank_q)
  );

  prg_hi_lines #(
    .BANK_W(BANK_W),
    .FORM  (FORM)
  ) u_hi (
    .bank_q  (bank_q),
    .fix_last(win_hi),
    .hi_out  (hi_lines)
  );

  assign prg_addr = {hi_lines, cpu_addr[WIN_W-1:0]};

  // R2: upper window pinned to the last bank.
  p_fixed_last_r2: assert property (@(negedge m2) disable iff (!rst_n)
    win_hi |-> (&prg_addr[PRG_W-1:WIN_W]));

  // R3: lower window follows the stored bank.
  p_lower_bank_r3: assert property (@(negedge m2) disable iff (!rst_n)
    !win_hi |-> (prg_addr[PRG_W-1:WIN_W] == bank_q));

  // R7: ROM is never enabled while the CPU writes.
  p_no_conflict_r7: assert property (@(negedge m2) disable iff (!rst_n)
    !cpu_rw |-> rom_ce_n);

endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m2 = 1'b0;
  logic        cpu_rw = 1'b1;
  logic        rom_sel_n = 1'b1;
  logic [14:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [16:0] prg_addr, prg_addr_pu;
  logic        rom_ce_n, rom_ce_n_pu;

  int vectors = 0;
  int misses  = 0;
  logic [2:0] model_bank = 3'd0;

  always #2 clk = ~clk;

  prg_bank_mapper u_prg_bank_mapper (
    .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .prg_addr(prg_addr), .rom_ce_n(rom_ce_n)
  );

  prg_bank_mapper #(.FORM(prg_map_pkg::HI_PULLUP)) u_prg_bank_mapper_pu (
    .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .prg_addr(prg_addr_pu), .rom_ce_n(rom_ce_n_pu)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One bus cycle; outputs checked while M2 is high, model updated at the fall.
  task automatic bus_cycle(input logic [15:0] addr, input logic rw,
                           input logic [7:0] data, input string tag);
    logic [2:0] exp_hi;
    @(posedge clk);
    cpu_addr = addr[14:0];
    cpu_rw   = rw;
    cpu_data = data;
    @(posedge clk);
    m2        = 1'b1;
    rom_sel_n = ~addr[15];
    @(negedge clk);
    exp_hi = addr[14] ? 3'b111 : model_bank;
    check("R1", {18'd0, prg_addr[13:0]}, {18'd0, addr[13:0]});
    check(addr[14] ? {"R2 ", tag} : {"R3 ", tag}, {29'd0, prg_addr[16:14]}, {29'd0, exp_hi});
    check("R7", {31'd0, rom_ce_n}, {31'd0, ~(addr[15] & rw)});
    check("R9", {14'd0, rom_ce_n_pu, prg_addr_pu}, {14'd0, rom_ce_n, prg_addr});
    @(posedge clk);
    m2 = 1'b0;
    if (rst_n && addr[15] && !rw && addr[14]) model_bank = data[2:0];
    if (!rst_n) model_bank = 3'd0;
    @(posedge clk);
    rom_sel_n = 1'b1;
  endtask

  initial begin : watchdog
    #800000;
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R8: reset state, lower window shows bank 0
    bus_cycle(16'h8000, 1'b1, 8'h00, "R8 reset");
    rst_n = 1'b1;
    bus_cycle(16'h9234, 1'b1, 8'h00, "R8 after release");

    // R4: every bank, with junk in the upper data bits, then window sweep
    for (int b = 0; b < 8; b++) begin
      bus_cycle(16'hC000 | 16'(b * 16'h0777), 1'b0, {5'(b * 5 + 3), 3'(b)}, "R4 store");
      for (int k = 0; k < 16; k++) begin
        bus_cycle(16'h8000 | 16'(k * 16'h0813 + b), 1'b1, 8'h00, "R4 read");
      end
    end

    // R5: store to lower window ignored
    bus_cycle(16'hC123, 1'b0, 8'hF2, "R4 store");
    bus_cycle(16'h8000, 1'b0, 8'h05, "R5 write");
    bus_cycle(16'hA000, 1'b1, 8'h00, "R5 after");
    bus_cycle(16'hBFFF, 1'b0, 8'h07, "R5 write");
    bus_cycle(16'h8001, 1'b1, 8'h00, "R5 after");

    // R6: store below $8000 with A14 set ignored; read of upper window ignored
    bus_cycle(16'h6000, 1'b0, 8'h06, "R6 write");
    bus_cycle(16'h8002, 1'b1, 8'h00, "R6 after");
    bus_cycle(16'h4020, 1'b0, 8'h01, "R6 write");
    bus_cycle(16'h8003, 1'b1, 8'h00, "R6 after");
    cpu_data = 8'h04;
    bus_cycle(16'hFFFC, 1'b1, 8'h04, "R6 read");
    bus_cycle(16'h8004, 1'b1, 8'h00, "R6 after");
    bus_cycle(16'h2000, 1'b1, 8'h00, "R7 low read");

    // R8: reset partway through
    bus_cycle(16'hE000, 1'b0, 8'h05, "R4 store");
    bus_cycle(16'h8005, 1'b1, 8'h00, "R4 read");
    #1 rst_n = 1'b0;
    model_bank = 3'd0;
    bus_cycle(16'hC000, 1'b0, 8'h03, "R8 held");
    bus_cycle(16'h8006, 1'b1, 8'h00, "R8 held");
    rst_n = 1'b1;
    bus_cycle(16'h8007, 1'b1, 8'h00, "R8 released");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule